// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block merges several reset requests into a single synchronous system reset of fixed length. The requests come from a flash-access error strobe, two clock-unit events (oscillator failure and alarm match), a software write to the block's status register, and the external active-low reset pin. The clock-failure detector, the alarm comparator and the power-on analog circuit live elsewhere. They reach this block only as level or strobe inputs, and `por_n` is the one asynchronous reset of the block itself.

The 8-bit status register records which cause produced the most recent reset. It is cleared only by power-on, so the flag survives the reset it describes. Each new reset clears the old cause flags and sets exactly one. The clock-unit path is enabled by a bit in the same register, and each of its two events has its own enable input. Only the power-on phase drives the external pin low. Flash, clock-unit, software and pin resets never drive the pin.

The control and status pins are plain levels and strobes. No data stream passes through the block, so it has no valid/ready handshake and applies no back-pressure.

Top module: `rst_combiner`

## Requirements
- R1: While `por_n` is low, and for 16 clock cycles after it rises, `sys_rst` and `ext_rst_drive` are 1 and `reg_rdata` reads 0x02 (bit 1 = power-on cause, clock-unit enable cleared). After that, both outputs are 0. `ext_rst_drive` is never 1 outside this power-on phase.
- R2: A reset accepted at a rising edge makes `sys_rst` 1 right after that edge, and it stays 1 for exactly 16 cycles.
- R3: A `flash_err` strobe sampled at an edge starts a reset at that edge. Afterwards bit 6 is the only cause flag set.
- R4: A register write with bit 7 = 1 enables the clock-unit source, and bit 7 reads back the enable. While the source is enabled, `rtc_fail` with `rtc_fail_en`, or `rtc_alarm` with `rtc_alarm_en`, starts a reset at that edge, and bit 5 is then the only cause flag set.
- R5: A clock-unit event has no effect when bit 7 is 0 or when that event's own enable input is 0.
- R6: A register write with bit 4 = 1 starts a software reset at that edge, and bit 4 then reads 1. A write with bit 4 = 0 starts no reset and changes no cause flag.
- R7: A falling edge on `ext_rst_n` passes through a 2-stage synchroniser and starts a reset at the third rising edge, counting the first edge that samples the pin low. Bit 0 is then the only cause flag set. Holding the pin low produces only one reset.
- R8: After every reset, exactly one of the cause bits {0,1,4,5,6} is 1. All other cause bits are cleared, and bits 2 and 3 always read 0.
- R9: When several requests arrive at the same edge, the flag that is recorded follows the priority flash error, then clock unit, then software, then pin.
- R10: While `sys_rst` is 1, every new request and every register write is ignored. The status register, including the enable bit, is unchanged.
- R11: While `sleep_mode` is 1, register writes are ignored, but the clock-unit reset path still works.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| ext_rst_n | input | 1 | External reset pin level, active low, asynchronous |
| flash_err | input | 1 | Flash illegal-access error strobe |
| rtc_fail | input | 1 | Clock-unit oscillator-failure event |
| rtc_fail_en | input | 1 | Enable for the oscillator-failure event |
| rtc_alarm | input | 1 | Clock-unit alarm-match event |
| rtc_alarm_en | input | 1 | Enable for the alarm-match event |
| sleep_mode | input | 1 | Low-power mode: register port is idle |
| reg_wr | input | 1 | Status register write strobe |
| reg_wdata | input | 8 | Write data (bit 7 = clock-unit enable, bit 4 = software reset) |
| reg_rdata | output | 8 | Status register read value |
| sys_rst | output | 1 | Synchronous system reset, active high |
| ext_rst_drive | output | 1 | Pulls the external pin low (power-on phase only) |

## Verification
Inputs change just after a falling edge. Flash, clock-unit and software requests are due to raise `sys_rst` one rising edge later, and a pin request three rising edges later. For each request, the driver pushes onto a scoreboard queue the cycle number at which the reset is due and the status value expected with it. The monitor samples on falling edges, compares the rise cycle and the status at the rise, and then times the pulse to 16 cycles. Any reset that the queue does not predict is a failure. Requests that must be ignored are followed by a quiet window and a status read.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
  localparam int STAT_W   = 8;
  localparam int B_PIN    = 0;
  localparam int B_POR    = 1;
  localparam int B_SOFT   = 4;
  localparam int B_CLK    = 5;
  localparam int B_FLASH  = 6;
  localparam int B_CLKEN  = 7;

  typedef enum logic [2:0] {
    CS_NONE,
    CS_FLASH,
    CS_CLOCK,
    CS_SOFT,
    CS_PIN
  } cause_e;
endpackage

// File: rtl/rstc_pin_sync.sv
module rstc_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic pin_n,
  output logic fall_o
);
  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      chain <= '1;
      last  <= 1'b1;
    end else begin
      chain[0] <= pin_n;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      last <= chain[STAGES-1];
    end
  end

  assign fall_o = last & ~chain[STAGES-1];
endmodule

// File: rtl/rstc_cause_arb.sv
module rstc_cause_arb
  import rstc_pkg::*;
(
  input  logic   flash_req,
  input  logic   clock_req,
  input  logic   soft_req,
  input  logic   pin_req,
  output cause_e cause_o,
  output logic   any_o
);
  always_comb begin
    if (flash_req)      cause_o = CS_FLASH;
    else if (clock_req) cause_o = CS_CLOCK;
    else if (soft_req)  cause_o = CS_SOFT;
    else if (pin_req)   cause_o = CS_PIN;
    else                cause_o = CS_NONE;
  end

  assign any_o = (cause_o != CS_NONE);
endmodule

// File: rtl/rstc_pulse_gen.sv
module rstc_pulse_gen #(
  parameter int LEN = 16
) (
  input  logic clk,
  input  logic por_n,
  input  logic load_i,
  output logic active_o,
  output logic por_phase_o
);
  localparam int CW = $clog2(LEN + 1);

  logic [CW-1:0] cnt;
  logic          por_phase;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt       <= CW'(LEN);
      por_phase <= 1'b1;
    end else if (load_i) begin
      cnt       <= CW'(LEN);
      por_phase <= 1'b0;
    end else if (cnt != '0) begin
      cnt <= cnt - CW'(1);
      if (cnt == CW'(1)) por_phase <= 1'b0;
    end
  end

  assign active_o    = (cnt != '0);
  assign por_phase_o = por_phase;

  // R2
  cnt_steps_down_chk: assert property (@(posedge clk) disable iff (!por_n)
    (cnt != '0) |=> (cnt == $past(cnt) - CW'(1)));

  // R1
  por_phase_inside_pulse_chk: assert property (@(posedge clk) disable iff (!por_n)
    por_phase |-> (cnt != '0));
endmodule

// File: rtl/rstc_status.sv
module rstc_status
  import rstc_pkg::*;
(
  input  logic              clk,
  input  logic              por_n,
  input  logic              capture_i,
  input  cause_e            cause_i,
  input  logic              en_wr_i,
  input  logic              en_val_i,
  output logic              clk_en_o,
  output logic [STAT_W-1:0] status_o
);
  logic [STAT_W-2:0] flags;
  logic              clk_en;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      flags  <= (STAT_W-1)'(1 << B_POR);
      clk_en <= 1'b0;
    end else begin
      if (capture_i) begin
        flags <= '0;
        case (cause_i)
          CS_FLASH: flags[B_FLASH] <= 1'b1;
          CS_CLOCK: flags[B_CLK]   <= 1'b1;
          CS_SOFT:  flags[B_SOFT]  <= 1'b1;
          CS_PIN:   flags[B_PIN]   <= 1'b1;
          default:  flags[B_POR]   <= 1'b1;
        endcase
      end
      if (en_wr_i) clk_en <= en_val_i;
    end
  end

  assign clk_en_o = clk_en;
  assign status_o = {clk_en, flags};

  // R8
  one_cause_flag_chk: assert property (@(posedge clk) disable iff (!por_n)
    $onehot(flags));

  // R10
  enable_held_without_write_chk: assert property (@(posedge clk) disable iff (!por_n)
    !en_wr_i |=> $stable(clk_en));
endmodule

// File: rtl/rst_combiner.sv
module rst_combiner
  import rstc_pkg::*;
#(
  parameter int PULSE_LEN   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              ext_rst_n,
  input  logic              flash_err,
  input  logic              rtc_fail,
  input  logic              rtc_fail_en,
  input  logic              rtc_alarm,
  input  logic              rtc_alarm_en,
  input  logic              sleep_mode,
  input  logic              reg_wr,
  input  logic [STAT_W-1:0] reg_wdata,
  output logic [STAT_W-1:0] reg_rdata,
  output logic              sys_rst,
  output logic              ext_rst_drive
);
  logic   pin_fall;
  logic   active;
  logic   por_phase;
  logic   wr_ok;
  logic   clock_req;
  logic   soft_req;
  logic   any_req;
  logic   load;
  logic   clk_en;
  cause_e cause;
  logic   unused_wdata;

  assign unused_wdata = ^{reg_wdata[B_CLKEN-1:B_SOFT+1], reg_wdata[B_SOFT-1:0]};

  rstc_pin_sync #(.STAGES(SYNC_STAGES)) u_pin (
    .clk    (clk),
    .por_n  (por_n),
    .pin_n  (ext_rst_n),
    .fall_o (pin_fall)
  );

  assign wr_ok     = reg_wr & ~sleep_mode & ~active;
  assign soft_req  = wr_ok & reg_wdata[B_SOFT];
  assign clock_req = clk_en & ((rtc_fail & rtc_fail_en) | (rtc_alarm & rtc_alarm_en));

  rstc_cause_arb u_arb (
    .flash_req (flash_err),
    .clock_req (clock_req),
    .soft_req  (soft_req),
    .pin_req   (pin_fall),
    .cause_o   (cause),
    .any_o     (any_req)
  );

  assign load = any_req & ~active;

  rstc_pulse_gen #(.LEN(PULSE_LEN)) u_pulse (
    .clk         (clk),
    .por_n       (por_n),
    .load_i      (load),
    .active_o    (active),
    .por_phase_o (por_phase)
  );

  rstc_status u_stat (
    .clk       (clk),
    .por_n     (por_n),
    .capture_i (load),
    .cause_i   (cause),
    .en_wr_i   (wr_ok),
    .en_val_i  (reg_wdata[B_CLKEN]),
    .clk_en_o  (clk_en),
    .status_o  (reg_rdata)
  );

  assign sys_rst       = active;
  assign ext_rst_drive = por_phase;

  // R1
  pin_drive_only_in_reset_chk: assert property (@(posedge clk) disable iff (!por_n)
    ext_rst_drive |-> sys_rst);

  // R10
  status_frozen_in_pulse_chk: assert property (@(posedge clk) disable iff (!por_n)
    (sys_rst && (flash_err || pin_fall || reg_wr || clock_req)) |=> $stable(reg_rdata));

  // R9
  flash_wins_chk: assert property (@(posedge clk) disable iff (!por_n)
    (flash_err && !sys_rst) |=> (reg_rdata[B_FLASH] && sys_rst && !ext_rst_drive));

  // R11
  sleep_keeps_enable_chk: assert property (@(posedge clk) disable iff (!por_n)
    sleep_mode |=> $stable(reg_rdata[B_CLKEN]));
endmodule

// File: tb/rst_combiner_test.sv
module rst_combiner_test;
  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       ext_rst_n = 1'b1;
  logic       flash_err = 1'b0;
  logic       rtc_fail = 1'b0, rtc_fail_en = 1'b0;
  logic       rtc_alarm = 1'b0, rtc_alarm_en = 1'b0;
  logic       sleep_mode = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       sys_rst, ext_rst_drive;

  always #2.5 clk = ~clk;

  rst_combiner uut (
    .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .flash_err(flash_err),
    .rtc_fail(rtc_fail), .rtc_fail_en(rtc_fail_en), .rtc_alarm(rtc_alarm),
    .rtc_alarm_en(rtc_alarm_en), .sleep_mode(sleep_mode), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sys_rst(sys_rst),
    .ext_rst_drive(ext_rst_drive)
  );

  typedef struct { int due; logic [7:0] st; string tag; } exp_t;
  exp_t sbq[$];

  int  cyc = 0;
  int  nchk = 0, nerr = 0;
  bit  mon_en = 0, done = 0, prev = 0;
  int  plen = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expectations when a reset pulse starts, times its length
  always @(negedge clk) begin
    if (mon_en) begin
      if (sys_rst && !prev) begin
        plen = 0;
        if (sbq.size() == 0) chk(0, "R10 unexpected reset", cyc, 0);
        else begin
          exp_t e;
          e = sbq.pop_front();
          chk(cyc == e.due, {e.tag, " rise cycle"}, cyc, e.due);
          chk(reg_rdata == e.st, {e.tag, " status"}, reg_rdata, e.st);
          chk(ext_rst_drive == 1'b0, "R1 pin not driven", ext_rst_drive, 0);
        end
      end
      if (sys_rst) plen++;
      if (!sys_rst && prev) chk(plen == 16, "R2 pulse length", plen, 16);
      prev = sys_rst;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain(input string tag);
    idle(24);
    chk(sbq.size() == 0, {tag, " scoreboard drained"}, sbq.size(), 0);
  endtask

  // drive one cycle of requests; optionally predict a reset one edge later
  task automatic fire(input logic f, input logic ofail, input logic alm, input logic wr,
                      input logic [7:0] wd, input bit exp_rst, input logic [7:0] exp_st,
                      input string tag);
    @(negedge clk);
    flash_err = f; rtc_fail = ofail; rtc_alarm = alm; reg_wr = wr; reg_wdata = wd;
    if (exp_rst) sbq.push_back('{due: cyc + 1, st: exp_st, tag: tag});
    @(negedge clk);
    flash_err = 0; rtc_fail = 0; rtc_alarm = 0; reg_wr = 0; reg_wdata = 8'h00;
  endtask

  initial begin
    idle(3);
    // R1 power-on phase
    chk(sys_rst == 1, "R1 rst during por", sys_rst, 1);
    chk(ext_rst_drive == 1, "R1 drive during por", ext_rst_drive, 1);
    chk(reg_rdata == 8'h02, "R1 status after por", reg_rdata, 8'h02);
    begin
      int c0;
      @(negedge clk);
      por_n = 1'b1;
      c0 = cyc;
      while (cyc < c0 + 15) @(negedge clk);
      chk(sys_rst == 1 && ext_rst_drive == 1, "R1 still held at 15", {sys_rst, ext_rst_drive}, 3);
      @(negedge clk);
      chk(sys_rst == 0 && ext_rst_drive == 0, "R1 released at 16", {sys_rst, ext_rst_drive}, 0);
    end
    prev = 0;
    mon_en = 1;
    idle(4);

    // R3 flash error
    fire(1, 0, 0, 0, 8'h00, 1, 8'h40, "R3 flash");
    drain("R3");
    // R6 software reset
    fire(0, 0, 0, 1, 8'h10, 1, 8'h10, "R6 software");
    drain("R6");
    // R4 enable clock unit, R6 write without bit 4 gives no reset
    fire(0, 0, 0, 1, 8'h80, 0, 8'h00, "R4");
    idle(4);
    chk(reg_rdata == 8'h90, "R4/R6 enable write no reset", reg_rdata, 8'h90);
    // R4 alarm and R8 old flag cleared
    rtc_alarm_en = 1;
    fire(0, 0, 1, 0, 8'h00, 1, 8'hA0, "R4/R8 alarm");
    drain("R4");
    rtc_alarm_en = 0; rtc_fail_en = 1;
    fire(1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1, 8'hA0, "R4 osc fail");
    drain("R4b");
    // R5 alarm with its event disabled
    fire(0, 0, 1, 0, 8'h00, 0, 8'h00, "R5");
    idle(20);
    chk(reg_rdata == 8'hA0, "R5 disabled alarm ignored", reg_rdata, 8'hA0);
    // R5 source disabled by bit 7
    fire(0, 0, 0, 1, 8'h00, 0, 8'h00, "R5");
    fire(0, 1, 0, 0, 8'h00, 0, 8'h00, "R5");
    idle(20);
    chk(reg_rdata == 8'h20, "R5 unenabled source ignored", reg_rdata, 8'h20);

    // R7 pin, held low several cycles
    @(negedge clk);
    ext_rst_n = 0;
    sbq.push_back('{due: cyc + 3, st: 8'h01, tag: "R7/R8 pin"});
    idle(6);
    ext_rst_n = 1;
    drain("R7");

    // R9 priority
    rtc_alarm_en = 1;
    fire(0, 0, 0, 1, 8'h80, 0, 8'h00, "R9");
    idle(2);
    chk(reg_rdata == 8'h81, "R9 enable set", reg_rdata, 8'h81);
    fire(1, 0, 1, 1, 8'h90, 1, 8'hC0, "R9 flash over clock/soft");
    drain("R9a");
    fire(0, 0, 1, 1, 8'h90, 1, 8'hA0, "R9 clock over soft");
    drain("R9b");

    // R10 requests and writes during a pulse ignored
    fire(0, 0, 0, 1, 8'h90, 1, 8'h90, "R10 soft");
    idle(2);
    fire(1, 0, 1, 1, 8'h00, 0, 8'h00, "R10");
    @(negedge clk);
    ext_rst_n = 0;
    idle(3);
    ext_rst_n = 1;
    drain("R10");
    chk(reg_rdata == 8'h90, "R10 status unchanged", reg_rdata, 8'h90);

    // R11 sleep mode
    sleep_mode = 1;
    fire(0, 0, 0, 1, 8'h10, 0, 8'h00, "R11");
    idle(20);
    chk(reg_rdata == 8'h90, "R11 write ignored in sleep", reg_rdata, 8'h90);
    fire(0, 0, 1, 0, 8'h00, 1, 8'hA0, "R11 clock in sleep");
    drain("R11");
    sleep_mode = 0;

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      chk(0, "watchdog", cyc, 0);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule